// File: doc/BRIEF.md
# UART Interrupt Status and FIFO Watermark Unit

This unit turns the fill levels of a UART's receive and transmit FIFOs, plus single-cycle receive event pulses, into an 11-bit interrupt status word. Two of the sources are level sources. They compare the current FIFO occupancy against a watermark chosen as a fraction of the FIFO depth. The other five sources latch their pulse and stay set until software clears them by writing a 1 to the matching clear bit.

A mask register selects which raw sources reach the masked status word. A single interrupt line is the OR of the masked bits. All three registers share one write port with a 2-bit register select: level-select, mask and clear. The FIFOs and the serial engines sit outside this block and provide the occupancy counts and the event pulses.

The block's outputs are combinational from its registers and the occupancy inputs. A register write or an event pulse therefore becomes visible immediately after the clock edge that captures it.

Top module: `uart_irq_status`

## Requirements
- R1: A write with `wr_sel` = 0 loads the level-select register from `wr_data[5:0]`. Bits [5:3] are the receive watermark code and bits [2:0] are the transmit watermark code.
- R2: The watermark codes 0, 1, 2, 3 and 4 give thresholds of DEPTH/8, DEPTH/4, DEPTH/2, 3*DEPTH/4 and 7*DEPTH/8. With DEPTH = 16 these are 2, 4, 8, 12 and 14.
- R3: Raw status bit 4 (receive level) is 1 exactly while `rx_count` is greater than or equal to the receive threshold.
- R4: Raw status bit 5 (transmit level) is 1 exactly while `tx_count` is less than or equal to the transmit threshold.
- R5: Watermark codes 5, 6 and 7 select the same threshold as code 4.
- R6: A pulse on an event input sets its latched raw bit from the next clock edge onward. The bits are timeout 6, framing 7, parity 8, break 9 and overrun 10. The bit holds its value while no clear arrives.
- R7: A write with `wr_sel` = 2 clears each latched bit whose `wr_data` bit is 1. Bits written 0 are unaffected, and `wr_data` = 0x7FF clears every latched source.
- R8: When a clear of a bit and that bit's event pulse arrive in the same cycle, the bit is 1 after the edge.
- R9: A write with `wr_sel` = 1 loads the 11-bit mask register. The masked status equals the raw status ANDed with the mask.
- R10: `irq` is 1 exactly when at least one masked status bit is 1.
- R11: Raw and masked status bits [3:0] are always 0.
- R12: After reset the mask, the level-select register and all latched bits are 0. With both counts at 0 the raw status is 0x020, the masked status is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| evt_timeout | input | 1 | Receive timeout pulse |
| evt_frame | input | 1 | Framing error pulse |
| evt_parity | input | 1 | Parity error pulse |
| evt_break | input | 1 | Break pulse |
| evt_overrun | input | 1 | Overrun pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 level-select, 1 mask, 2 clear, 3 none |
| wr_data | input | 11 | Write data |
| raw_status | output | 11 | Raw interrupt status |
| masked_status | output | 11 | Raw status ANDed with mask |
| irq | output | 1 | Combined interrupt |

## Verification
The following hold on every cycle:
- an event sets its latched bit on the next edge, even when a clear arrives in the same cycle;
- a clear without an event drops the bit, and a latched bit otherwise holds;
- the masked word never shows a bit that the raw word lacks;
- the low four status bits stay 0;
- a zero mask keeps `irq` low;
- codes 5 to 7 behave like the top threshold.

The actual threshold values for each code, the direction of each watermark comparison, the field positions in the level-select write, and write-one-to-clear of individual bits are shown only by the bench's scenarios. Those scenarios sweep every code at and just beyond its threshold.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned STAT_W    = 11;
    localparam int unsigned BIT_RXLVL = 4;
    localparam int unsigned BIT_TXLVL = 5;
    localparam int unsigned EVT_BASE  = 6;
    localparam int unsigned EVT_N     = 5;

    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CLEAR = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    // Watermark code to eighths of FIFO depth; unused codes saturate.
    function automatic int unsigned wm_eighths(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/uart_wm_compare.sv
module uart_wm_compare
    import uart_irq_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned CNT_W   = $clog2(DEPTH + 1),
    parameter bit          RX_SIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] TOP_THR = CNT_W'((DEPTH * 7) / 8);

    logic [CNT_W-1:0] thr;

    always_comb begin
        thr = CNT_W'((DEPTH * wm_eighths(code)) / 8);
    end

    generate
        if (RX_SIDE) begin : g_rx
            always_comb hit = (count >= thr);
            p_top_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (code >= 3'd4) |-> (hit == (count >= TOP_THR)));
        end else begin : g_tx
            always_comb hit = (count <= thr);
            p_top_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (code >= 3'd4) |-> (hit == (count <= TOP_THR)));
        end
    endgenerate
endmodule

// File: rtl/uart_evt_latch.sv
module uart_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= evt | (q & ~clr);
    end

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> q);
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !q);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt) |=> (q == $past(q)));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              evt_timeout,
    input  logic              evt_frame,
    input  logic              evt_parity,
    input  logic              evt_break,
    input  logic              evt_overrun,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] raw_status,
    output logic [STAT_W-1:0] masked_status,
    output logic              irq
);
    wr_sel_e           sel;
    logic [5:0]        lvl_q;
    logic [STAT_W-1:0] mask_q;
    logic [EVT_N-1:0]  evt_vec;
    logic [EVT_N-1:0]  clr_vec;
    logic [EVT_N-1:0]  lat_q;
    logic              rx_hit;
    logic              tx_hit;

    always_comb sel = wr_sel_e'(wr_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_LEVEL: lvl_q  <= wr_data[5:0];
                SEL_MASK:  mask_q <= wr_data;
                default:   ;
            endcase
        end
    end

    uart_wm_compare #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RX_SIDE(1'b1)) u_rx_wm (
        .clk(clk), .rst_n(rst_n), .code(lvl_q[5:3]), .count(rx_count), .hit(rx_hit));

    uart_wm_compare #(.DEPTH(DEPTH), .CNT_W(CNT_W), .RX_SIDE(1'b0)) u_tx_wm (
        .clk(clk), .rst_n(rst_n), .code(lvl_q[2:0]), .count(tx_count), .hit(tx_hit));

    always_comb begin
        evt_vec = {evt_overrun, evt_break, evt_parity, evt_frame, evt_timeout};
        clr_vec = (wr_en && sel == SEL_CLEAR) ? wr_data[EVT_BASE +: EVT_N] : '0;
    end

    generate
        for (genvar i = 0; i < EVT_N; i++) begin : g_evt
            uart_evt_latch u_lat (
                .clk(clk), .rst_n(rst_n), .evt(evt_vec[i]), .clr(clr_vec[i]), .q(lat_q[i]));
        end
    endgenerate

    always_comb begin
        raw_status                     = '0;
        raw_status[BIT_RXLVL]          = rx_hit;
        raw_status[BIT_TXLVL]          = tx_hit;
        raw_status[EVT_BASE +: EVT_N]  = lat_q;
        masked_status                  = raw_status & mask_q;
        irq                            = |masked_status;
    end

    p_masked_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0);
    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (mask_q == $past(wr_data)));
    p_zero_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    p_low_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status[3:0] == 4'd0) && (masked_status[3:0] == 4'd0));
endmodule

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
    localparam int D  = 16;
    localparam int CW = 5;

    typedef struct {
        logic [10:0] raw;
        logic [10:0] msk;
        logic        irq;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic ev_to = 0, ev_fr = 0, ev_pa = 0, ev_br = 0, ev_ov = 0;
    logic wr_en = 0;
    logic [1:0] wr_sel = 2'd3;
    logic [10:0] wr_data = '0;
    logic [10:0] raw_status, masked_status;
    logic irq;

    int n_checks = 0, n_fail = 0;
    exp_t sb[$];

    // Reference state
    logic [5:0]  m_lvl = '0;
    logic [10:0] m_mask = '0;
    logic [4:0]  m_lat = '0;

    always #10 clk = ~clk;

    uart_irq_status #(.DEPTH(D), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .evt_timeout(ev_to), .evt_frame(ev_fr), .evt_parity(ev_pa),
        .evt_break(ev_br), .evt_overrun(ev_ov), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .raw_status(raw_status), .masked_status(masked_status),
        .irq(irq));

    function automatic int mthr(input logic [2:0] c);
        case (c)
            3'd0: return D / 8;
            3'd1: return D / 4;
            3'd2: return D / 2;
            3'd3: return (3 * D) / 4;
            default: return (7 * D) / 8;
        endcase
    endfunction

    function automatic void compare(input exp_t e);
        n_checks++;
        if (raw_status !== e.raw || masked_status !== e.msk || irq !== e.irq) begin
            n_fail++;
            $display("FAIL %s: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                     e.tag, raw_status, masked_status, irq, e.raw, e.msk, e.irq);
        end
    endfunction

    task automatic step(input int rxc, input int txc, input logic [4:0] ev,
                        input logic we, input logic [1:0] sel, input logic [10:0] d,
                        input string tag);
        exp_t e;
        logic [4:0] clr;
        rx_count = CW'(rxc);
        tx_count = CW'(txc);
        {ev_ov, ev_br, ev_pa, ev_fr, ev_to} = ev;
        wr_en = we; wr_sel = sel; wr_data = d;
        clr = (we && sel == 2'd2) ? d[10:6] : 5'd0;
        m_lat = ev | (m_lat & ~clr);
        if (we && sel == 2'd0) m_lvl = d[5:0];
        if (we && sel == 2'd1) m_mask = d;
        e.raw = {m_lat, (txc <= mthr(m_lvl[2:0])), (rxc >= mthr(m_lvl[5:3])), 4'b0};
        e.msk = e.raw & m_mask;
        e.irq = |e.msk;
        e.tag = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
        {ev_ov, ev_br, ev_pa, ev_fr, ev_to} = 5'd0;
        wr_en = 1'b0;
        @(negedge clk);
        #1;
    endtask

    // Monitor: compares results against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        r.raw = 11'h020; r.msk = 11'h000; r.irq = 1'b0; r.tag = "R12 reset";
        compare(r);
        #1;

        step(0, 0, 5'd0, 1'b1, 2'd1, 11'h7FF, "R9 R10 mask all");
        // Sweep every watermark code on both sides
        for (int c = 0; c < 8; c++) begin
            int t;
            t = mthr(3'(c));
            step(t - 1, t + 1, 5'd0, 1'b1, 2'd0, {5'd0, 3'(c), 3'(c)},
                 c > 4 ? "R5 below" : "R2 R3 R4 below");
            step(t, t, 5'd0, 1'b0, 2'd3, 11'd0, c > 4 ? "R5 at" : "R2 R3 R4 at");
        end
        // R1: fields are not swapped (rx code 3, tx code 0)
        step(12, 2, 5'd0, 1'b1, 2'd0, 11'h018, "R1 both hit");
        step(11, 3, 5'd0, 1'b0, 2'd3, 11'd0, "R1 neither");
        // R6: each event latches and holds
        step(0, 20, 5'b00001, 1'b0, 2'd3, 11'd0, "R6 timeout");
        step(0, 20, 5'b00010, 1'b0, 2'd3, 11'd0, "R6 frame");
        step(0, 20, 5'b00100, 1'b0, 2'd3, 11'd0, "R6 parity");
        step(0, 20, 5'b01000, 1'b0, 2'd3, 11'd0, "R6 break");
        step(0, 20, 5'b10000, 1'b0, 2'd3, 11'd0, "R6 overrun");
        step(0, 20, 5'd0, 1'b0, 2'd3, 11'd0, "R6 hold");
        // R7: clear behaviour
        step(0, 20, 5'd0, 1'b1, 2'd2, 11'h000, "R7 zero write");
        step(0, 20, 5'd0, 1'b1, 2'd2, 11'h080, "R7 clear frame");
        step(0, 20, 5'd0, 1'b1, 2'd2, 11'h00F, "R11 low clear bits");
        // R8: event beats clear
        step(0, 20, 5'b00001, 1'b1, 2'd2, 11'h040, "R8 event wins");
        step(0, 20, 5'd0, 1'b1, 2'd2, 11'h7FF, "R7 clear all");
        // R9/R10: partial mask
        step(0, 20, 5'b00011, 1'b1, 2'd1, 11'h080, "R9 partial mask");
        step(0, 20, 5'd0, 1'b1, 2'd2, 11'h080, "R10 masked source cleared");
        step(0, 0, 5'd0, 1'b1, 2'd1, 11'h000, "R10 zero mask");
        step(16, 0, 5'b11111, 1'b1, 2'd1, 11'h7FF, "R11 all set");
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule